// File: doc/BRIEF.md
# UART Transmit Holding Stage and Line Status

This block is the transmit half of a serial port. Characters from the host enter a holding stage, which is one register in character mode and a 16-entry first-in first-out queue in queued mode. They then move into a shift register that drives the serial output line. Each serial bit is 16 baud ticks wide. The line carries a start bit, the data least significant bit first, an optional parity bit and one or more stop bits.

Two read-only status flags report how far the pipeline has drained. The holding-empty flag (`thre`) tracks only the holding stage. The transmitter-empty flag (`temt`) also requires the shift register to be idle. The holding-empty flag, gated by its enable, forms the interrupt request. When the mode select changes, the holding stage is flushed. A character that is already shifting always completes.

The shift controller has five states. TX_IDLE holds the line at mark (1). TX_START drives 0. TX_DATA drives the current data bit. TX_PARITY drives the parity bit. TX_STOP drives 1. The transitions are as follows:
- LOAD: TX_IDLE goes to TX_START when the holding stage has a character.
- BIT_END: TX_START goes to TX_DATA after 16 ticks.
- DATA_DONE: TX_DATA goes to TX_PARITY after the last data bit, or to TX_STOP when parity is off.
- PAR_DONE: TX_PARITY goes to TX_STOP.
- CHAIN: TX_STOP goes straight to TX_START when the last stop bit ends and another character waits.
- DRAIN: TX_STOP goes to TX_IDLE when the last stop bit ends and no character waits.

Top module: `uart_txhold`

## Requirements
- R1: After reset, `txd` is 1, `thre` is 1, `temt` is 1 and `irq` is 0 while `thre_ie` is 0.
- R2: A write that is accepted makes `thre` 0 in the cycle after the write edge. In character mode, `thre` returns to 1 one cycle later, when the character moves into the shift register, provided the shifter was idle.
- R3: `temt` is 1 only when the holding stage is empty and the shifter is in TX_IDLE. It rises when the last stop bit of the last queued character ends. `thre` is 1 and `txd` is 1 whenever `temt` is 1.
- R4: Each frame is one start bit of 0, then 8 data bits least significant bit first, then one even-parity bit (the XOR of the data bits), then one stop bit of 1. Each bit lasts 16 baud ticks, and the state changes only on a tick.
- R5: A waiting character begins its start bit directly after the previous stop bit, with no idle time. A burst of N characters therefore takes exactly N*176 ticks.
- R6: In character mode, a write while the holding register is occupied and no transfer occurs replaces the held character. Only the last value written is sent.
- R7: In queued mode, the holding stage stores 16 characters. A write while all 16 are stored is ignored, and that byte never appears on `txd`.
- R8: In queued mode, `thre` stays 0 while at least one byte is queued. It becomes 1 when the last byte enters the shift register, while `temt` stays 0 until that byte has been sent.
- R9: `irq` equals `thre` AND `thre_ie`.
- R10: A change of `fifo_mode` empties the holding stage in the following cycle, so `thre` is 1. The character already in the shift register is still sent complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for the holding stage |
| wr_data | input | 8 | Character to transmit |
| fifo_mode | input | 1 | 1 selects queued mode, 0 selects character mode |
| thre_ie | input | 1 | Enable for the holding-empty interrupt |
| baud_tick | input | 1 | One pulse per 1/16 bit time |
| txd | output | 1 | Serial output, 1 when idle |
| thre | output | 1 | Holding stage empty |
| temt | output | 1 | Holding stage and shift register both empty |
| irq | output | 1 | Holding-empty interrupt request |

## Verification
A wrong holding-stage count shows up one cycle after the write edge, as a `thre` value that disagrees with the number of bytes written minus the number transferred. It also shows up later as a missing, duplicated or extra frame on `txd`. A wrong shifter state or tick count corrupts a frame within one bit time: the bit sampled in the middle of that bit is wrong. A wrong chaining decision lengthens a burst by at least one bit time and moves the rising edge of `temt`.

// File: rtl/uart_txhold_pkg.sv
package uart_txhold_pkg;
    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_t;
endpackage

// File: rtl/uart_txhold_stage.sv
module uart_txhold_stage #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              push, over;

    // queued mode drops writes at full; character mode accepts into an empty
    // slot or into the slot being freed this cycle, and overwrites otherwise
    always_comb begin
        push = 1'b0;
        over = 1'b0;
        if (wr_en && !flush) begin
            if (fifo_mode) begin
                push = (count != CNT_FULL);
            end else begin
                push = (count == '0) || pop;
                over = (count != '0) && !pop;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wr_data;
        end else if (over) begin
            mem[rd_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_data = mem[rd_ptr];
    assign empty   = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_FULL); // R7
    AST_CHAR_MODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_mode && !flush && count <= 1) |=> (count <= 1)); // R6
endmodule

// File: rtl/uart_txhold_shifter.sv
module uart_txhold_shifter
    import uart_txhold_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int OVS       = 16,
    parameter int STOP_BITS = 1,
    parameter bit PAR_EN    = 1'b1,
    parameter bit PAR_ODD   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              avail,
    input  logic [DATA_W-1:0] din,
    output logic              load,
    output logic              txd,
    output logic              busy
);
    localparam int TICK_W = $clog2(OVS);
    localparam int MAXB   = (DATA_W > STOP_BITS) ? DATA_W : STOP_BITS;
    localparam int BIT_W  = $clog2(MAXB + 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(OVS - 1);
    localparam logic [BIT_W-1:0]  DATA_LAST = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0]  STOP_LAST = BIT_W'(STOP_BITS - 1);

    tx_state_t          state, state_nx;
    logic [TICK_W-1:0]  tick_cnt;
    logic [BIT_W-1:0]   bit_idx;
    logic [DATA_W-1:0]  shreg;
    logic               par_bit;
    logic               bit_end, last_data, last_stop;

    assign bit_end   = baud_tick && (tick_cnt == TICK_LAST);
    assign last_data = bit_end && (bit_idx == DATA_LAST);
    assign last_stop = bit_end && (bit_idx == STOP_LAST);

    // next state
    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            TX_IDLE: begin
                if (avail) begin
                    state_nx = TX_START;
                    load     = 1'b1;
                end
            end
            TX_START:  if (bit_end) state_nx = TX_DATA;
            TX_DATA:   if (last_data) state_nx = PAR_EN ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) state_nx = TX_STOP;
            TX_STOP: begin
                if (last_stop) begin
                    if (avail) begin
                        state_nx = TX_START;
                        load     = 1'b1;
                    end else begin
                        state_nx = TX_IDLE;
                    end
                end
            end
            default: state_nx = TX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_bit  <= 1'b0;
        end else if (load) begin
            tick_cnt <= '0;
            bit_idx  <= '0;
            shreg    <= din;
            par_bit  <= (^din) ^ PAR_ODD;
        end else if (state != TX_IDLE && baud_tick) begin
            tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
            if (bit_end && state == TX_DATA) begin
                shreg   <= shreg >> 1;
                bit_idx <= last_data ? '0 : bit_idx + 1'b1;
            end else if (bit_end && state == TX_STOP) begin
                bit_idx <= last_stop ? '0 : bit_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        txd = 1'b1;
        unique case (state)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_bit;
            TX_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end
    assign busy = (state != TX_IDLE);

    AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && state_nx != state) |-> baud_tick); // R4
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) |-> txd); // R4
endmodule

// File: rtl/uart_txhold.sv
module uart_txhold #(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16,
    parameter int STOP_BITS  = 1,
    parameter bit PAR_EN     = 1'b1,
    parameter bit PAR_ODD    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fifo_mode,
    input  logic              thre_ie,
    input  logic              baud_tick,
    output logic              txd,
    output logic              thre,
    output logic              temt,
    output logic              irq
);
    logic              mode_q, flush;
    logic              pop, empty, busy;
    logic [DATA_W-1:0] hold_data;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= fifo_mode;
    end
    assign flush = (fifo_mode != mode_q);

    uart_txhold_stage #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) stage_i (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .flush(flush),
        .wr_en(wr_en), .wr_data(wr_data), .pop(pop),
        .rd_data(hold_data), .empty(empty)
    );

    uart_txhold_shifter #(
        .DATA_W(DATA_W), .OVS(OVS), .STOP_BITS(STOP_BITS),
        .PAR_EN(PAR_EN), .PAR_ODD(PAR_ODD)
    ) shifter_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .avail(!empty && !flush), .din(hold_data),
        .load(pop), .txd(txd), .busy(busy)
    );

    assign thre = empty;
    assign temt = empty && !busy;
    assign irq  = thre && thre_ie;

    AST_WRITE_CLEARS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> !thre); // R2
    AST_TEMT_IMPLIES_THRE: assert property (@(posedge clk) disable iff (!rst_n)
        temt |-> (thre && txd)); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> thre); // R10
endmodule

// File: tb/uart_txhold_tb_top.sv
`timescale 1ns/1ps
module uart_txhold_tb_top;
    localparam int P   = 2;   // clock cycles per baud tick
    localparam int OVS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_mode = 1'b0;
    logic       thre_ie = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, thre, temt, irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int div = 0;
    logic done = 1'b0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        div <= (div == P - 1) ? 0 : div + 1;
        baud_tick <= (div == P - 1);
    end

    uart_txhold dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_mode(fifo_mode), .thre_ie(thre_ie), .baud_tick(baud_tick),
        .txd(txd), .thre(thre), .temt(temt), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: one write, returns at the negedge after the write edge
    task automatic wr(input logic [7:0] b, input bit expect_sent);
        wr_en = 1'b1;
        wr_data = b;
        if (expect_sent) exp_q.push_back(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (temt !== 1'b1) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // monitor: decode frames and compare against the scoreboard queue
    initial begin
        logic prev;
        logic [7:0] d;
        logic pbit, sbit;
        logic [7:0] e;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev === 1'b1 && txd === 1'b0) begin
                repeat (8 * P) @(negedge clk);
                check("R4 start bit", {31'b0, txd}, 32'd0);
                for (int i = 0; i < 8; i++) begin
                    repeat (OVS * P) @(negedge clk);
                    d[i] = txd;
                end
                repeat (OVS * P) @(negedge clk);
                pbit = txd;
                repeat (OVS * P) @(negedge clk);
                sbit = txd;
                if (exp_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R7 unexpected frame actual=%0h expected=none", d);
                end else begin
                    e = exp_q.pop_front();
                    check("R4/R6/R7 frame data", {24'b0, d}, {24'b0, e});
                    check("R4 parity", {31'b0, pbit}, {31'b0, ^e});
                    check("R4 stop bit", {31'b0, sbit}, 32'd1);
                end
            end
            prev = txd;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        int t0;
        int span;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 txd", {31'b0, txd}, 32'd1);
        check("R1 thre", {31'b0, thre}, 32'd1);
        check("R1 temt", {31'b0, temt}, 32'd1);
        check("R1 irq", {31'b0, irq}, 32'd0);
        thre_ie = 1'b1;
        @(negedge clk);
        check("R9 irq with enable", {31'b0, irq}, 32'd1);

        // R2 character mode, single write
        wr(8'hA5, 1'b1);
        check("R2 thre after write", {31'b0, thre}, 32'd0);
        check("R3 temt after write", {31'b0, temt}, 32'd0);
        check("R9 irq low", {31'b0, irq}, 32'd0);
        @(negedge clk);
        check("R2 thre after transfer", {31'b0, thre}, 32'd1);
        check("R3 temt while shifting", {31'b0, temt}, 32'd0);
        wait_idle();
        check("R3 temt after frame", {31'b0, temt}, 32'd1);

        // R6 overwrite in character mode
        wr(8'h3C, 1'b1);
        @(negedge clk);
        wr(8'h77, 1'b0);
        check("R6 thre held", {31'b0, thre}, 32'd0);
        wr(8'hC2, 1'b1);
        wait_idle();

        // R7/R8/R5 queued mode burst with overflow
        fifo_mode = 1'b1;
        repeat (3) @(negedge clk);
        t0 = cyc;
        for (int i = 0; i < 18; i++) begin
            wr(8'(i * 37 + 5), i < 17);
        end
        check("R8 thre while queued", {31'b0, thre}, 32'd0);
        check("R9 irq while queued", {31'b0, irq}, 32'd0);
        while (thre !== 1'b1) @(negedge clk);
        check("R8 temt during last frame", {31'b0, temt}, 32'd0);
        while (temt !== 1'b1) @(negedge clk);
        span = cyc - t0;
        check("R5 burst length", {31'b0, (span >= 17*176*P - 4) && (span <= 17*176*P + 8)}, 32'd1);
        repeat (4) @(negedge clk);

        // R10 mode change flushes pending bytes
        wr(8'h5A, 1'b1);
        wr(8'h81, 1'b0);
        wr(8'h99, 1'b0);
        check("R10 thre before flush", {31'b0, thre}, 32'd0);
        fifo_mode = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 thre after flush", {31'b0, thre}, 32'd1);
        check("R10 temt shift continues", {31'b0, temt}, 32'd0);
        wait_idle();
        thre_ie = 1'b0;
        @(negedge clk);
        check("R9 irq disabled", {31'b0, irq}, 32'd0);
        check("R7 scoreboard drained", exp_q.size(), 32'd0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule